// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets on-chip logic read and write an external asynchronous static RAM with an 18-bit address and an 8-bit data bus. A caller raises `req` with an address, a direction and, for stores, a data byte; the controller takes the request on a clock edge where `ready` is high. It then plays out the pin sequence for that access, stretching each phase over enough clock cycles to meet the memory's timing. Read data comes back on `rdata` with a one-cycle `rvalid` strobe.

The memory is selected only while an active-low select is low and an active-high select is high, and a store happens only while both selects and the active-low write enable overlap. The controller therefore raises both selects and the address one cycle before the write strobe falls, and keeps everything, data included, one cycle after the strobe rises. Between accesses it parks the memory in standby and releases its data drivers. After every load it waits, with the output enable high, long enough for the memory's outputs to go high-impedance before anything else may drive the bus.

All phase lengths come from the clock period and the speed-grade times, which are parameters. A phase of t ns lasts ceil(t / clock period) cycles, never fewer than one. The data bus is split into an output, an output enable and an input, to be joined at the pad.

Top module: `asram_ctrl`

## Requirements
- R1: A synchronous active-high reset forces the idle state on the next clock edge. While idle, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `ready`=1 and `rvalid`=0.
- R2: A request is taken only on a clock edge where `req` and `ready` are both high. `ready` then stays low until the access sequence has finished, and `req` has no effect during that time. After every access there is at least one idle cycle with `ready` high.
- R3: A load keeps both selects active, `mem_oe_n` low, `mem_we_n` high and `mem_dq_oe` low for N_RD = max(c(T_RC), c(T_AA), c(T_OE)) cycles, starting in the cycle after acceptance.
- R4: Read data is sampled from `mem_dq_in` at the clock edge that ends the last load cycle. `rdata` holds that byte from the next cycle on, and `rvalid` is high for exactly that one cycle.
- R5: After a load comes a turnaround of N_TA = c(max(T_OHZ, T_HZ)) cycles. During it the memory is deselected, `mem_oe_n` is high and `ready` is low.
- R6: A store begins with one setup cycle: both selects active, the address valid, `mem_we_n` high, `mem_oe_n` high and the data bus released.
- R7: `mem_we_n` is then low for N_WP cycles, the smallest count that satisfies all of these: N_WP ≥ c(T_WP), N_WP ≥ c(T_DW), N_WP+1 ≥ c(T_CW), N_WP+1 ≥ c(T_AW) and N_WP+2 ≥ c(T_WC). The store byte is driven from the first of these cycles.
- R8: A store ends with one hold cycle: `mem_we_n` high, with both selects, the address and the data byte still driven.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low. `mem_we_n` is low only while both selects are active and `mem_oe_n` is high.
- R10: The cycle count for a time t ns is c(t) = max(1, ceil(t / CLK_NS)).
- R11: The address and the store byte are captured at acceptance. They stay stable on the pins for the whole access, whatever `addr` and `wdata` do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = store, 0 = load |
| addr | input | 18 | Access address |
| wdata | input | 8 | Store byte |
| ready | output | 1 | Controller idle, request can be taken |
| rdata | output | 8 | Last loaded byte |
| rvalid | output | 1 | One-cycle strobe: `rdata` is new |
| mem_addr | output | 18 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The bench builds the block with a 10 ns clock and the fastest grade's times. These give a 7-cycle load, a 6-cycle write pulse and a 3-cycle turnaround. The phase counter therefore runs through several non-trivial terminal counts, and the turnaround is long enough that a shortened one would collide with the memory model's output window. The memory model checks pulse width, data setup, select and address windows, and access time at cycle granularity, and returns inverted data if sampled too early. A load followed directly by a store is one of the sequences applied, so the bus handover is exercised.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_READ = 3'd1,
    PH_TURN = 3'd2,
    PH_WSET = 3'd3,
    PH_WPUL = 3'd4,
    PH_WHLD = 3'd5
  } phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R10: cycles covering t_ns, never fewer than one
  function automatic int cycles_for(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int read_len(input int t_rc, input int t_aa, input int t_oe,
                                  input int clk_ns);
    return max_of(cycles_for(t_rc, clk_ns),
                  max_of(cycles_for(t_aa, clk_ns), cycles_for(t_oe, clk_ns)));
  endfunction

  function automatic int turn_len(input int t_ohz, input int t_hz, input int clk_ns);
    return cycles_for(max_of(t_ohz, t_hz), clk_ns);
  endfunction

  // setup and hold cycles each add one to the select and address windows
  function automatic int pulse_len(input int t_wp, input int t_dw, input int t_cw,
                                   input int t_aw, input int t_wc, input int clk_ns);
    int n;
    n = max_of(cycles_for(t_wp, clk_ns), cycles_for(t_dw, clk_ns));
    n = max_of(n, cycles_for(t_cw, clk_ns) - 1);
    n = max_of(n, cycles_for(t_aw, clk_ns) - 1);
    n = max_of(n, cycles_for(t_wc, clk_ns) - 2);
    return max_of(n, 1);
  endfunction

  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
`timescale 1ns/1ps
module asram_phase_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int            CW    = 3,
  parameter logic [CW-1:0] LD_RD = '0,
  parameter logic [CW-1:0] LD_TA = '0,
  parameter logic [CW-1:0] LD_WP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic          cnt_zero,
  output phase_e        phase,
  output logic          ready,
  output logic          accept,
  output logic          cap,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val
);

  always_comb begin
    ready    = (phase == PH_IDLE);
    accept   = ready && req;
    cap      = (phase == PH_READ) && cnt_zero;
    cnt_load = 1'b0;
    cnt_val  = LD_RD;
    if (accept && !req_wr) begin
      cnt_load = 1'b1;
    end else if (cap) begin
      cnt_load = 1'b1;
      cnt_val  = LD_TA;
    end else if (phase == PH_WSET) begin
      cnt_load = 1'b1;
      cnt_val  = LD_WP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) phase <= req_wr ? PH_WSET : PH_READ;
        PH_READ: if (cnt_zero) phase <= PH_TURN;
        PH_TURN: if (cnt_zero) phase <= PH_IDLE;
        PH_WSET: phase <= PH_WPUL;
        PH_WPUL: if (cnt_zero) phase <= PH_WHLD;
        PH_WHLD: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: setup lasts exactly one cycle and leads into the pulse
  a_r6_setup_one: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WSET) |=> (phase == PH_WPUL));

  // R5: a load is always followed by the turnaround
  a_r5_read_to_turn: assert property (@(posedge clk) disable iff (rst)
    cap |=> (phase == PH_TURN));

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath
  import asram_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  input  phase_e        phase,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= addr;
      dq_out   <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= dq_in;
    end
  end

  // R11: address and store byte frozen while an access runs
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(mem_addr));
  a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(dq_out));

  // R4: rvalid is a single-cycle strobe
  a_r4_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
module asram_pins
  import asram_pkg::*;
#(
  parameter int N_WP = 6,
  parameter int N_TA = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  output logic   sel_n,
  output logic   sel,
  output logic   we_n,
  output logic   oe_n,
  output logic   dq_oe
);

  localparam logic [15:0] WP_L  = 16'(N_WP);
  localparam logic [7:0]  TA_L  = 8'(N_TA);
  localparam logic [7:0]  SAT_L = 8'hFF;

  logic active;

  always_comb begin
    active = (phase == PH_READ) || (phase == PH_WSET) ||
             (phase == PH_WPUL) || (phase == PH_WHLD);
    sel_n  = !active;
    sel    = active;
    we_n   = (phase != PH_WPUL);
    oe_n   = (phase != PH_READ);
    dq_oe  = (phase == PH_WPUL) || (phase == PH_WHLD);
  end

  // observation counters for the checks below
  logic [15:0] wlow;
  logic [7:0]  oe_hi;

  always_ff @(posedge clk) begin
    if (rst)        wlow <= '0;
    else if (!we_n) wlow <= wlow + 1'b1;
    else            wlow <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 oe_hi <= SAT_L;
    else if (!oe_n)          oe_hi <= '0;
    else if (oe_hi != SAT_L) oe_hi <= oe_hi + 1'b1;
  end

  // R7: write strobe low for exactly the computed pulse length
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (wlow == WP_L));

  // R5: bus drive only after output enable has been high long enough
  a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (oe_hi >= TA_L));

  // R9: never drive against an enabled memory output
  a_r9_no_drive_oe: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  // R9: write strobe only inside a full select with outputs off
  a_r9_we_in_sel: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!sel_n && sel && oe_n));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW     = 18,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int T_RC   = 70,
  parameter int T_AA   = 70,
  parameter int T_OE   = 35,
  parameter int T_OHZ  = 25,
  parameter int T_HZ   = 25,
  parameter int T_WC   = 70,
  parameter int T_WP   = 55,
  parameter int T_CW   = 60,
  parameter int T_AW   = 60,
  parameter int T_DW   = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int N_RD = read_len(T_RC, T_AA, T_OE, CLK_NS);
  localparam int N_TA = turn_len(T_OHZ, T_HZ, CLK_NS);
  localparam int N_WP = pulse_len(T_WP, T_DW, T_CW, T_AW, T_WC, CLK_NS);
  localparam int CW   = cnt_bits(max_of(N_RD, max_of(N_TA, N_WP)));
  localparam logic [CW-1:0] LD_RD = CW'(N_RD - 1);
  localparam logic [CW-1:0] LD_TA = CW'(N_TA - 1);
  localparam logic [CW-1:0] LD_WP = CW'(N_WP - 1);

  phase_e        phase;
  logic          accept;
  logic          cap;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;

  asram_seq #(
    .CW(CW), .LD_RD(LD_RD), .LD_TA(LD_TA), .LD_WP(LD_WP)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .cnt_zero(cnt_zero),
    .phase(phase), .ready(ready), .accept(accept), .cap(cap),
    .cnt_load(cnt_load), .cnt_val(cnt_val)
  );

  asram_phase_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .accept(accept), .addr(addr), .wdata(wdata),
    .cap(cap), .dq_in(mem_dq_in), .phase(phase), .mem_addr(mem_addr),
    .dq_out(mem_dq_out), .rdata(rdata), .rvalid(rvalid)
  );

  asram_pins #(.N_WP(N_WP), .N_TA(N_TA)) u_pins (
    .clk(clk), .rst(rst), .phase(phase), .sel_n(mem_sel_n), .sel(mem_sel),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  // R1: an idle controller keeps the memory in standby with the bus released
  a_r1_ready_standby: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2: a taken request makes the port busy
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (req && ready) |=> !ready);

endmodule

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  localparam int CLK_NS = 10;
  localparam int T_RC = 70, T_AA = 70, T_OE = 35, T_OHZ = 25, T_HZ = 25;
  localparam int T_WC = 70, T_WP = 55, T_CW = 60, T_AW = 60, T_DW = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [17:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mdq = '0;

  always #(CLK_NS / 2) clk = ~clk;

  asram_ctrl #(
    .CLK_NS(CLK_NS), .T_RC(T_RC), .T_AA(T_AA), .T_OE(T_OE), .T_OHZ(T_OHZ),
    .T_HZ(T_HZ), .T_WC(T_WC), .T_WP(T_WP), .T_CW(T_CW), .T_AW(T_AW), .T_DW(T_DW)
  ) dut_i (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mdq)
  );

  int vec = 0;
  int mis = 0;
  bit done = 1'b0;

  // R10: smallest cycle count whose span reaches t
  function automatic int need(input int t);
    int n = 1;
    while (n * CLK_NS < t) n++;
    return n;
  endfunction

  int e_rd, e_ta, e_wp, e_hz;

  function automatic logic [7:0] dflt(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h3C;
  endfunction

  logic [7:0] shad [logic [17:0]];
  logic [7:0] mmem [logic [17:0]];

  typedef struct {
    bit rdy, sel, wen, oen, doe, rv, chk_d;
    logic [17:0] a;
    logic [7:0]  d, rd;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic exp_t idle_e();
    exp_t e;
    e.rdy = 1; e.sel = 0; e.wen = 1; e.oen = 1; e.doe = 0; e.rv = 0; e.chk_d = 0;
    e.a = '0; e.d = '0; e.rd = '0; e.tag = "R2";
    return e;
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    mis++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  task automatic push_read(input logic [17:0] a);
    exp_t e;
    logic [7:0] v;
    v = shad.exists(a) ? shad[a] : dflt(a);
    for (int i = 0; i < e_rd; i++) begin
      e = idle_e(); e.rdy = 0; e.sel = 1; e.oen = 0; e.a = a; e.tag = "R3,R10";
      q.push_back(e);
    end
    for (int i = 0; i < e_ta; i++) begin
      e = idle_e(); e.rdy = 0; e.tag = "R5";
      if (i == 0) begin e.rv = 1; e.rd = v; e.tag = "R4,R5"; end
      q.push_back(e);
    end
  endtask

  task automatic push_write(input logic [17:0] a, input logic [7:0] d);
    exp_t e;
    e = idle_e(); e.rdy = 0; e.sel = 1; e.a = a; e.tag = "R6";
    q.push_back(e);
    for (int i = 0; i < e_wp; i++) begin
      e = idle_e(); e.rdy = 0; e.sel = 1; e.wen = 0; e.doe = 1; e.chk_d = 1;
      e.a = a; e.d = d; e.tag = "R7,R10";
      q.push_back(e);
    end
    e = idle_e(); e.rdy = 0; e.sel = 1; e.doe = 1; e.chk_d = 1; e.a = a; e.d = d;
    e.tag = "R8";
    q.push_back(e);
    shad[a] = d;
  endtask

  // behavioural memory with cycle-granular timing checks
  int sel_age = 0, addr_age = 0, oe_age = 0, hz_left = 0;
  int wlen = 0, dage = 0, s_at = 0, a_at = 0;
  logic [17:0] last_a = '0, wa = '0;
  logic [7:0]  wd = '0, last_d = '0;

  always @(negedge clk) begin
    bit sel, win, rd_on, busy;
    exp_t e;
    logic [7:0] v;
    sel   = !mem_sel_n && mem_sel;
    win   = sel && !mem_we_n;
    rd_on = sel && mem_we_n && !mem_oe_n;
    sel_age = sel ? sel_age + 1 : 0;
    if (sel) addr_age = (mem_addr == last_a && addr_age > 0) ? addr_age + 1 : 1;
    else     addr_age = 0;
    if (rd_on && oe_age > 0 && mem_addr != last_a)
      fail("R11", "address moved during load", mem_addr, last_a);
    last_a = mem_addr;
    oe_age = rd_on ? oe_age + 1 : 0;
    busy = rd_on || hz_left > 0;
    if (!rst && mem_dq_oe && busy) fail("R5,R9", "bus contention", 1, 0);
    if (rd_on) hz_left = e_hz;
    else if (hz_left > 0) hz_left--;
    if (win) begin
      if (wlen == 0) wa = mem_addr;
      else if (mem_addr != wa) fail("R11", "address moved during store", mem_addr, wa);
      wlen++;
      dage = (mem_dq_oe && mem_dq_out == last_d && dage > 0) ? dage + 1 : (mem_dq_oe ? 1 : 0);
      last_d = mem_dq_out; wd = mem_dq_out; s_at = sel_age; a_at = addr_age;
    end else if (wlen > 0) begin
      if (wlen * CLK_NS < T_WP) fail("R7", "write pulse ns", wlen * CLK_NS, T_WP);
      if (dage * CLK_NS < T_DW) fail("R7", "data setup ns", dage * CLK_NS, T_DW);
      if (s_at * CLK_NS < T_CW) fail("R7", "select window ns", s_at * CLK_NS, T_CW);
      if (a_at * CLK_NS < T_AW) fail("R7", "address window ns", a_at * CLK_NS, T_AW);
      if (!rst) mmem[wa] = wd;
      wlen = 0; dage = 0;
    end
    if (rd_on) begin
      v = mmem.exists(mem_addr) ? mmem[mem_addr] : dflt(mem_addr);
      mdq = (oe_age * CLK_NS >= T_OE && addr_age * CLK_NS >= T_AA) ? v : ~v;
    end else begin
      mdq = 8'h00;
    end

    // cycle-by-cycle comparison against the expected pin trace
    if (!rst) begin
      e = (q.size() > 0) ? q.pop_front() : idle_e();
      vec++;
      if (ready != e.rdy)         fail(e.tag, "ready", ready, e.rdy);
      if (mem_sel_n != !e.sel)    fail(e.tag, "sel_n", mem_sel_n, !e.sel);
      if (mem_sel != e.sel)       fail(e.tag, "sel", mem_sel, e.sel);
      if (mem_we_n != e.wen)      fail(e.tag, "we_n", mem_we_n, e.wen);
      if (mem_oe_n != e.oen)      fail(e.tag, "oe_n", mem_oe_n, e.oen);
      if (mem_dq_oe != e.doe)     fail(e.tag, "dq_oe", mem_dq_oe, e.doe);
      if (rvalid != e.rv)         fail(e.tag, "rvalid", rvalid, e.rv);
      if (e.sel && mem_addr != e.a) fail({e.tag, ",R11"}, "mem_addr", mem_addr, e.a);
      if (e.chk_d && mem_dq_out != e.d) fail({e.tag, ",R11"}, "dq_out", mem_dq_out, e.d);
      if (e.rv && rdata != e.rd)  fail(e.tag, "rdata", rdata, e.rd);
    end
  end

  task automatic check_idle(input string tag);
    vec++;
    if (!(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && ready && !rvalid))
      fail(tag, "reset idle pins", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, ready, rvalid},
           7'b1011010);
  endtask

  task automatic issue(input bit w, input logic [17:0] a, input logic [7:0] d, input bit junk);
    while (ready !== 1'b1) begin @(negedge clk); #1; end
    req = 1; req_wr = w; addr = a; wdata = d;
    if (w) push_write(a, d); else push_read(a);
    @(negedge clk); #1;
    addr = a ^ 18'h2D2D2; wdata = ~d;
    req = 0;
    if (junk) begin
      // R2: requests while busy must leave the trace untouched
      req = 1; req_wr = ~w;
      repeat (3) begin @(negedge clk); #1; end
      req = 0;
    end
  endtask

  initial begin
    e_rd = need(T_RC); if (need(T_AA) > e_rd) e_rd = need(T_AA);
    if (need(T_OE) > e_rd) e_rd = need(T_OE);
    e_hz = need(T_OHZ > T_HZ ? T_OHZ : T_HZ);
    e_ta = e_hz;
    e_wp = 1;
    while (!(e_wp >= need(T_WP) && e_wp >= need(T_DW) && e_wp + 1 >= need(T_CW) &&
             e_wp + 1 >= need(T_AW) && e_wp + 2 >= need(T_WC))) e_wp++;
    repeat (3) @(negedge clk);
    check_idle("R1");
    #1 rst = 0;
    issue(0, 18'h00000, 8'h00, 0);
    issue(0, 18'h3FFFF, 8'h00, 0);
    issue(1, 18'h3FFFF, 8'hA5, 0);
    issue(0, 18'h3FFFF, 8'h00, 0);
    issue(1, 18'h00000, 8'h5A, 0);
    issue(0, 18'h00000, 8'h00, 0);
    for (int i = 0; i < 6; i++) begin
      issue(1, 18'h1 << (i * 3), 8'h80 ^ (8'h11 * i), 0);
      issue(0, 18'h1 << (i * 3), 8'h00, 0);
    end
    issue(0, 18'h00155, 8'h00, 0);
    issue(1, 18'h00155, 8'hC3, 0);
    issue(0, 18'h00155, 8'h00, 0);
    issue(1, 18'h2AAAA, 8'h69, 1);
    issue(0, 18'h2AAAA, 8'h00, 1);
    issue(0, 18'h2AAAA ^ 18'h2D2D2, 8'h00, 0);
    // R1: reset in the middle of a load
    issue(0, 18'h01234, 8'h00, 0);
    repeat (2) begin @(negedge clk); #1; end
    rst = 1; q.delete();
    repeat (2) @(negedge clk);
    check_idle("R1");
    #1 rst = 0;
    issue(1, 18'h01234, 8'h3E, 0);
    issue(0, 18'h01234, 8'h00, 0);
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mis++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end

endmodule